// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block turns one 16-bit instruction word of a small 32-bit register machine into decoded control fields. The machine has sixteen general registers. The top bits of the word select one of three layouts:

- a register-operand layout with an 8-bit primary opcode;
- a short-immediate layout with a 2-bit sub-opcode, one register and an 8-bit unsigned immediate;
- a conditional-branch layout with a 4-bit condition and a 10-bit word displacement.

From the opcode class the decoder also works out how long the instruction is. That is 2 bytes, or 6 bytes when a 32-bit literal word follows the instruction word. It also flags encodings that have no defined meaning, and it marks instructions that change the program flow.

The fetch stage presents a word together with a one-cycle valid strobe. All outputs are registered. They appear on the clock edge that samples the strobe and then hold until the next strobe. Fields that do not belong to the decoded layout read as zero, so downstream logic can use them without masking. Execution, memory traffic and register writes belong to later stages.

Top module: `idec_top`

## Requirements
- R1: While reset is asserted and after its release, until the first strobe, every output reads zero. This includes `dec_valid` and the layout code.
- R2: `dec_valid` is high for exactly the cycle after each cycle with `in_valid` high. All decoded outputs load at that edge and stay unchanged while `in_valid` is low, whatever `in_word` does.
- R3: A word with bit 15 clear decodes as layout code 1. The outputs are `dec_opc` = bits 15:8, `dec_ra` = bits 7:4 and `dec_rb` = bits 3:0. `dec_imm`, `dec_cond` and `dec_disp` read zero.
- R4: A word with bits 15:14 = 2'b10 decodes as layout code 2. The outputs are `dec_opc` = bits 13:12 zero-extended, `dec_ra` = bits 11:8 and `dec_imm` = bits 7:0. `dec_rb`, `dec_cond` and `dec_disp` read zero. Sub-opcodes 0..3 mean add immediate, subtract immediate, read special register and write special register. None of them is illegal.
- R5: A word with bits 15:14 = 2'b11 decodes as layout code 3. The outputs are `dec_cond` = bits 13:10, `dec_opc` = the condition zero-extended, and `dec_disp` = bits 9:0 sign-extended and multiplied by two (a byte displacement). `dec_ra`, `dec_rb` and `dec_imm` read zero.
- R6: `dec_len` is 6 for the layout-1 opcodes that carry a 32-bit literal. These are 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36..0x39. `dec_len` is 2 for every other word, including illegal words and all layout-2 and layout-3 words.
- R7: A layout-1 opcode outside 0x00..0x0E and 0x19..0x39 sets `dec_bad`.
- R8: A layout-3 condition above 9 sets `dec_bad`. Conditions 0..9 leave it clear.
- R9: `dec_xfer` is set for every legal layout-3 word and for the layout-1 opcodes 0x03, 0x04, 0x19, 0x1A and 0x25. It is clear for every other word, and always clear when `dec_bad` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: `in_word` holds an instruction this cycle |
| in_word | input | 16 | Instruction word |
| dec_valid | output | 1 | Pulses the cycle after a strobe |
| dec_fmt | output | 2 | Layout code: 0 none, 1 register, 2 short immediate, 3 branch |
| dec_opc | output | 8 | Primary opcode, sub-opcode or condition, zero-extended |
| dec_ra | output | 4 | First register index |
| dec_rb | output | 4 | Second register index |
| dec_imm | output | 8 | Unsigned 8-bit immediate |
| dec_cond | output | 4 | Branch condition |
| dec_disp | output | OFS_W (32) | Signed byte displacement of a branch |
| dec_len | output | 3 | Instruction length in bytes (2 or 6) |
| dec_bad | output | 1 | Undefined encoding |
| dec_xfer | output | 1 | Instruction changes program flow |

## Verification
Each strobe is decoded into one self-contained register snapshot, so a wrong internal state always shows up in the cycle right after the offending strobe. A mis-split field appears in the wrong output, and a wrong class table shows as a bad length, legality or transfer bit. A lost hold shows the next time inputs toggle without a strobe. The bench therefore drives every layout-1 opcode, every branch condition and every sub-opcode, and compares each one a single cycle after its strobe. It also moves `in_word` between strobes to expose any leak past the capture enable.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int WORD_W   = 16;
  localparam int OPC_W    = 8;
  localparam int RIDX_W   = 4;
  localparam int IMM_W    = 8;
  localparam int COND_W   = 4;
  localparam int RAWOFS_W = 10;
  localparam int LEN_W    = 3;

  localparam logic [LEN_W-1:0]  LEN_SHORT = 3'd2;
  localparam logic [LEN_W-1:0]  LEN_LONG  = 3'd6;
  localparam logic [COND_W-1:0] COND_MAX  = 4'd9;

  typedef enum logic [1:0] {
    FMT_NONE     = 2'd0,
    FMT_REGOP    = 2'd1,
    FMT_SHORTIMM = 2'd2,
    FMT_BRANCH   = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [IMM_W-1:0]  imm;
    logic [COND_W-1:0] cond;
  } fields_s;

  // register-operand opcodes that exist
  function automatic logic op_defined(input logic [OPC_W-1:0] op);
    return (op <= 8'h0E) || ((op >= 8'h19) && (op <= 8'h39));
  endfunction

  // register-operand opcodes followed by a 32-bit literal word
  function automatic logic op_has_literal(input logic [OPC_W-1:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B,
      8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
      8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  // register-operand opcodes that redirect the program counter
  function automatic logic op_redirects(input logic [OPC_W-1:0] op);
    case (op)
      8'h03, 8'h04, 8'h19, 8'h1A, 8'h25: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/idec_split.sv
// Layout selection and field extraction; purely combinational.
module idec_split
  import idec_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output fields_s           flds,
  output logic [OFS_W-1:0]  disp
);
  localparam int EXT_W = OFS_W - RAWOFS_W - 1;

  logic [RAWOFS_W-1:0] raw_ofs;
  logic [OFS_W-1:0]    scaled;

  assign raw_ofs = word[RAWOFS_W-1:0];

  // sign-extend the word displacement, then scale it to bytes
  generate
    if (EXT_W > 0) begin : g_wide
      assign scaled = {{EXT_W{raw_ofs[RAWOFS_W-1]}}, raw_ofs, 1'b0};
    end else begin : g_narrow
      assign scaled = {raw_ofs[OFS_W-2:0], 1'b0};
    end
  endgenerate

  always_comb begin
    flds = '0;
    disp = '0;
    if (!word[15]) begin
      flds.fmt = FMT_REGOP;
      flds.opc = word[15:8];
      flds.ra  = word[7:4];
      flds.rb  = word[3:0];
    end else if (!word[14]) begin
      flds.fmt = FMT_SHORTIMM;
      flds.opc = {6'd0, word[13:12]};
      flds.ra  = word[11:8];
      flds.imm = word[7:0];
    end else begin
      flds.fmt  = FMT_BRANCH;
      flds.cond = word[13:10];
      flds.opc  = {4'd0, word[13:10]};
      disp      = scaled;
    end
  end
endmodule

// File: rtl/idec_rules.sv
// Length, legality and flow-change class of an already split word.
module idec_rules
  import idec_pkg::*;
(
  input  fields_s           flds,
  output logic [LEN_W-1:0]  len,
  output logic              bad,
  output logic              xfer
);
  always_comb begin
    len  = LEN_SHORT;
    bad  = 1'b0;
    xfer = 1'b0;
    unique case (flds.fmt)
      FMT_REGOP: begin
        bad  = !op_defined(flds.opc);
        len  = op_has_literal(flds.opc) ? LEN_LONG : LEN_SHORT;
        xfer = op_redirects(flds.opc);
      end
      FMT_BRANCH: begin
        bad  = flds.cond > COND_MAX;
        xfer = !bad;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  output logic              dec_valid,
  output logic [1:0]        dec_fmt,
  output logic [7:0]        dec_opc,
  output logic [3:0]        dec_ra,
  output logic [3:0]        dec_rb,
  output logic [7:0]        dec_imm,
  output logic [3:0]        dec_cond,
  output logic [OFS_W-1:0]  dec_disp,
  output logic [2:0]        dec_len,
  output logic              dec_bad,
  output logic              dec_xfer
);
  fields_s           nx_flds;
  logic [OFS_W-1:0]  nx_disp;
  logic [LEN_W-1:0]  nx_len;
  logic              nx_bad;
  logic              nx_xfer;

  fields_s           q_flds;
  logic [OFS_W-1:0]  q_disp;
  logic [LEN_W-1:0]  q_len;
  logic              q_bad;
  logic              q_xfer;
  logic              q_valid;

  // named event: a word is being captured this cycle
  logic capture_evt;
  assign capture_evt = in_valid;

  idec_split #(.OFS_W(OFS_W)) u_split (
    .word (in_word),
    .flds (nx_flds),
    .disp (nx_disp)
  );

  idec_rules u_rules (
    .flds (nx_flds),
    .len  (nx_len),
    .bad  (nx_bad),
    .xfer (nx_xfer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_flds  <= '0;
      q_disp  <= '0;
      q_len   <= '0;
      q_bad   <= 1'b0;
      q_xfer  <= 1'b0;
    end else begin
      q_valid <= capture_evt;
      if (capture_evt) begin
        q_flds <= nx_flds;
        q_disp <= nx_disp;
        q_len  <= nx_len;
        q_bad  <= nx_bad;
        q_xfer <= nx_xfer;
      end
    end
  end

  assign dec_valid = q_valid;
  assign dec_fmt   = q_flds.fmt;
  assign dec_opc   = q_flds.opc;
  assign dec_ra    = q_flds.ra;
  assign dec_rb    = q_flds.rb;
  assign dec_imm   = q_flds.imm;
  assign dec_cond  = q_flds.cond;
  assign dec_disp  = q_disp;
  assign dec_len   = q_len;
  assign dec_bad   = q_bad;
  assign dec_xfer  = q_xfer;

  // ---------------- assertions ----------------
  assert_strobe_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> dec_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> !dec_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_evt && $past(rst_n)) |=>
      $stable({dec_fmt, dec_opc, dec_ra, dec_rb, dec_imm, dec_cond, dec_disp,
               dec_len, dec_bad, dec_xfer}));

  assert_len_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_len == LEN_SHORT || dec_len == LEN_LONG));

  assert_branch_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_fmt == FMT_BRANCH) |-> dec_len == LEN_SHORT);

  assert_shortimm_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_fmt == FMT_SHORTIMM) |-> !dec_bad);

  assert_bad_no_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bad |-> !dec_xfer);

endmodule

// File: tb/idec_top_tb.sv
module idec_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;

  logic        dec_valid;
  logic [1:0]  dec_fmt;
  logic [7:0]  dec_opc;
  logic [3:0]  dec_ra, dec_rb, dec_cond;
  logic [7:0]  dec_imm;
  logic [31:0] dec_disp;
  logic [2:0]  dec_len;
  logic        dec_bad, dec_xfer;

  always #(CLK_PERIOD/2) clk = ~clk;

  idec_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .dec_valid(dec_valid), .dec_fmt(dec_fmt), .dec_opc(dec_opc),
    .dec_ra(dec_ra), .dec_rb(dec_rb), .dec_imm(dec_imm), .dec_cond(dec_cond),
    .dec_disp(dec_disp), .dec_len(dec_len), .dec_bad(dec_bad), .dec_xfer(dec_xfer)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic [7:0]  opc;
    logic [3:0]  ra, rb;
    logic [7:0]  imm;
    logic [3:0]  cond;
    logic [31:0] disp;
    logic [2:0]  len;
    logic        bad, xfer;
  } exp_s;

  exp_s queue_q[$];
  exp_s last_exp;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;

  function automatic exp_s actual();
    exp_s a;
    a = '{dec_fmt, dec_opc, dec_ra, dec_rb, dec_imm, dec_cond, dec_disp,
          dec_len, dec_bad, dec_xfer};
    return a;
  endfunction

  // Reference model written from the requirements
  function automatic exp_s model(input logic [15:0] w);
    exp_s e;
    int   op, d;
    e = '0;
    e.len = 3'd2;
    if (w[15] == 1'b0) begin                 // R3
      op = int'(w[15:8]);
      e.fmt = 2'd1; e.opc = w[15:8]; e.ra = w[7:4]; e.rb = w[3:0];
      e.bad = !((op >= 0 && op <= 14) || (op >= 25 && op <= 57));        // R7
      if (op inside {1, 3, 8, 9, 12, 13, 26, 27, 29, 31, 32, 34, 36, 48,
                     54, 55, 56, 57}) e.len = 3'd6;                      // R6
      e.xfer = (op inside {3, 4, 25, 26, 37});                           // R9
    end else if (w[14] == 1'b0) begin        // R4
      e.fmt = 2'd2; e.opc = {6'd0, w[13:12]}; e.ra = w[11:8]; e.imm = w[7:0];
    end else begin                           // R5
      e.fmt = 2'd3; e.cond = w[13:10]; e.opc = {4'd0, w[13:10]};
      d = int'(w[9:0]);
      if (d >= 512) d = d - 1024;
      e.disp = 32'(d * 2);
      e.bad  = int'(w[13:10]) > 9;                                       // R8
      e.xfer = !e.bad;                                                   // R9
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req,
                       input exp_s act, input exp_s exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one strobe, expected result into the scoreboard
  task automatic drive(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    queue_q.push_back(model(w));
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;    // toggle the bus while idle
  endtask

  // monitor: compares each decoded result in the cycle after its strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dec_valid) begin
        exp_s e;
        if (queue_q.size() == 0) begin
          check(1'b0, "R2 unexpected valid", actual(), '0);
        end else begin
          e = queue_q.pop_front();
          last_exp = e;
          check(actual() === e,
                e.fmt == 2'd1 ? "R3/R6/R7/R9" :
                e.fmt == 2'd2 ? "R4/R8" : "R5/R8/R9",
                actual(), e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(actual() === '0 && dec_valid === 1'b0, "R1 during reset", actual(), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(actual() === '0 && dec_valid === 1'b0, "R1 after release", actual(), '0);

    // R3/R6/R7/R9: every register-operand opcode
    for (int op = 0; op < 128; op++) drive({op[7:0], 4'(op), 4'(~op)});
    // R4: all sub-opcodes with varied register and immediate
    for (int s = 0; s < 4; s++) drive({2'b10, s[1:0], 4'(s * 5 + 3), 8'(8'hA5 ^ s)});
    drive(16'hBFFF);
    drive(16'h8000);
    // R5/R8: every condition, positive and negative displacements
    for (int c = 0; c < 16; c++) drive({2'b11, c[3:0], 10'(c * 37)});
    drive({2'b11, 4'd0, 10'h200});   // most negative
    drive({2'b11, 4'd1, 10'h1FF});   // most positive
    drive({2'b11, 4'd2, 10'h3FF});   // -1 word

    // R2: hold while idle with the bus moving
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      in_word = 16'(k * 16'h3C3C + 16'h1234);
      @(negedge clk);
      check(actual() === last_exp && dec_valid === 1'b0,
            "R2 hold while idle", actual(), last_exp);
    end

    // R2: back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; in_word = 16'h0E21; queue_q.push_back(model(16'h0E21));
    @(negedge clk);
    in_word = 16'hC7FE; queue_q.push_back(model(16'hC7FE));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(queue_q.size() == 0, "R2 all results delivered", '0, '0);
    finish_run();
  end
endmodule